// File: doc/BRIEF.md
# Prescaled Capture Timer with Pulse-Width Clear

This block is a free-running 16-bit up-counter driven through a 16-bit prescaler. The prescaler advances on every clock in timer mode. In counter mode it advances only on rising edges of an external count pin. The counter steps once each time the prescaler completes a full period of programmed-limit-plus-one ticks.

Two capture channels watch their own pins. Each pin is synchronised and edge-detected. When an enabled edge arrives, the channel stores the current counter value. A channel can also be set to zero the counter and the prescaler when it fires. To measure a pulse width, one channel clears the counter on the leading edge and a second channel captures on the trailing edge, so the stored value is the width with no subtraction.

Software reaches the block through a small register bus. Writes are single-cycle and reads are combinational. Sticky capture flags drive one interrupt line.

Top module: `pwcap_timer`

## Requirements
- R1: After reset, every readable register (addresses 0 to 7) reads zero and `irq` is low.
- R2: In timer mode, with control bit 0 (run) set, the prescaler count (address 7) goes up by one per clock. When it reaches or exceeds the limit at address 1, it returns to 0 and the counter (address 6) goes up by one. The counter therefore advances once every limit+1 clocks.
- R3: With control bit 2 (external mode) set, each rising edge on `cnt_in` replaces the clock as the prescaler tick, so the counter advances once per limit+1 rising edges.
- R4: With run clear and no clear event, the counter and the prescaler hold their values.
- R5: While control bit 1 (hold-clear) is set, the counter and the prescaler stay at zero, whatever the run bit says.
- R6: `cap_in[i]` passes through two synchroniser flops and an edge detector. Channel i's capture register (address 4+i) loads the counter value on a rising edge when config bit 4i is set, and on a falling edge when config bit 4i+1 is set (config register at address 2). A pin change made before clock edge k is stored at edge k+2. Edges of a disabled polarity leave the register unchanged.
- R7: When config bit 4i+3 is set, a capture event on channel i zeroes the counter and the prescaler at the same edge. This clear takes priority over any increment. With the leading edge clearing and the trailing edge capturing, a pulse of N clocks reads back floor((N-1)/(limit+1)).
- R8: A capture on channel i with config bit 4i+2 set raises flag bit i (address 3). The flag is sticky until software writes 1 to that bit, and writing 0 leaves it set. `irq` is the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe for one clock |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| cap_in | input | 2 | Capture pins, one per channel |
| cnt_in | input | 1 | External count pin |
| irq | output | 1 | Interrupt request, OR of the sticky flags |

## Verification
Pulse-width measurement is driven from a table of prescale limits and pulse lengths. The table covers a one-clock pulse, lengths that are exact multiples of the prescale period, and lengths that are not. A readback that is one too high or one too low shows whether the clear and capture edges are aligned and whether the prescaler was zeroed along with the counter. Directed runs then check timer stepping, external-edge counting, freeze, hold-clear, and the exact capture latency with a disabled polarity. A final directed run checks that the sticky flags stay set until software clears them with a write of 1.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIMIT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAPCFG = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd3;
  localparam int               A_CAP0   = 4;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd6;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd7;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_HOLD = 1;
  localparam int CTRL_EXT  = 2;
  localparam int CFG_W     = 4;
endpackage

// File: rtl/pwcap_edge_sync.sv
module pwcap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic lvl_prev
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl      = chain_q[STAGES-1];
  assign lvl_prev = prev_q;
endmodule

// File: rtl/pwcap_count_core.sv
module pwcap_count_core #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             ext_mode,
  input  logic             ext_rise,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc_lim,
  output logic [CNT_W-1:0] count,
  output logic [PSC_W-1:0] psc
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic             tick;
  logic             upd;

  always_comb begin
    tick  = run & (ext_mode ? ext_rise : 1'b1);
    cnt_d = cnt_q;
    psc_d = psc_q;
    upd   = 1'b0;
    if (hold || clr) begin
      cnt_d = '0;
      psc_d = '0;
      upd   = 1'b1;
    end else if (tick) begin
      upd = 1'b1;
      if (psc_q >= psc_lim) begin
        psc_d = '0;
        cnt_d = cnt_q + CNT_W'(1);
      end else begin
        psc_d = psc_q + PSC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      psc_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      psc_q <= psc_d;
    end
  end

  assign count = cnt_q;
  assign psc   = psc_q;

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0 && psc_q == '0));
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && psc_q == '0));
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold && !clr) |=> ($stable(cnt_q) && $stable(psc_q)));
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == '0));
endmodule

// File: rtl/pwcap_cap_chan.sv
module pwcap_cap_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             en_rise,
  input  logic             en_fall,
  input  logic [CNT_W-1:0] count,
  output logic             hit,
  output logic [CNT_W-1:0] cap_val
);
  logic             lvl, lvl_prev;
  logic [CNT_W-1:0] cap_q;

  pwcap_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  assign hit = (en_rise & lvl & ~lvl_prev) | (en_fall & ~lvl & lvl_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (hit) cap_q <= count;
  end

  assign cap_val = cap_q;

  a_r6_load_count: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cap_q == $past(count)));
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap_q));
endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
  import pwcap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int N_CAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_CAP-1:0]  cap_in,
  input  logic              cnt_in,
  output logic              irq
);
  localparam int CFG_BITS = CFG_W * N_CAP;

  logic [1:0]          rst_pipe;
  logic                rst_i_n;
  logic [2:0]          ctrl_q;
  logic [PSC_W-1:0]    lim_q;
  logic [CFG_BITS-1:0] cfg_q;
  logic [N_CAP-1:0]    flag_q, flag_d, hit, w1c;
  logic [CNT_W-1:0]    count;
  logic [PSC_W-1:0]    psc;
  logic [CNT_W-1:0]    cap_val [N_CAP];
  logic                cnt_lvl, cnt_prev;
  logic                clr_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  pwcap_edge_sync #(.STAGES(2)) u_cnt_sync (
    .clk(clk), .rst_n(rst_i_n), .pin(cnt_in), .lvl(cnt_lvl), .lvl_prev(cnt_prev)
  );

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    pwcap_cap_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_i_n), .pin(cap_in[i]),
      .en_rise(cfg_q[CFG_W*i]), .en_fall(cfg_q[CFG_W*i+1]),
      .count(count), .hit(hit[i]), .cap_val(cap_val[i])
    );
  end

  always_comb begin
    clr_any = 1'b0;
    w1c     = '0;
    if (bus_we && bus_addr == A_FLAGS) w1c = bus_wdata[N_CAP-1:0];
    for (int i = 0; i < N_CAP; i++) begin
      clr_any   = clr_any | (hit[i] & cfg_q[CFG_W*i+3]);
      flag_d[i] = (hit[i] & cfg_q[CFG_W*i+2]) | (flag_q[i] & ~w1c[i]);
    end
  end

  pwcap_count_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk(clk), .rst_n(rst_i_n),
    .run(ctrl_q[CTRL_RUN]), .hold(ctrl_q[CTRL_HOLD]), .ext_mode(ctrl_q[CTRL_EXT]),
    .ext_rise(cnt_lvl & ~cnt_prev), .clr(clr_any), .psc_lim(lim_q),
    .count(count), .psc(psc)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      lim_q  <= '0;
      cfg_q  <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (bus_we && bus_addr == A_CTRL)   ctrl_q <= bus_wdata[2:0];
      if (bus_we && bus_addr == A_LIMIT)  lim_q  <= bus_wdata[PSC_W-1:0];
      if (bus_we && bus_addr == A_CAPCFG) cfg_q  <= bus_wdata[CFG_BITS-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = DATA_W'(ctrl_q);
      A_LIMIT:  bus_rdata = DATA_W'(lim_q);
      A_CAPCFG: bus_rdata = DATA_W'(cfg_q);
      A_FLAGS:  bus_rdata = DATA_W'(flag_q);
      A_COUNT:  bus_rdata = DATA_W'(count);
      A_PSC:    bus_rdata = DATA_W'(psc);
      default:  bus_rdata = '0;
    endcase
    for (int i = 0; i < N_CAP; i++)
      if (bus_addr == ADDR_W'(A_CAP0 + i)) bus_rdata = DATA_W'(cap_val[i]);
  end

  assign irq = |flag_q;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~w1c)) == $past(flag_q & ~w1c)));
  a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flag_q == '0 && hit == '0) |=> !irq);
endmodule

// File: tb/pwcap_timer_tb.sv
module pwcap_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  cap_in = '0;
  logic        cnt_in = 1'b0;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;

  // pulse table: {prescale limit, pulse length in clocks}
  localparam logic [31:0] VEC [8] = '{
    {16'd0, 16'd1}, {16'd0, 16'd7}, {16'd0, 16'd40}, {16'd3, 16'd40},
    {16'd4, 16'd9}, {16'd2, 16'd3}, {16'd9, 16'd100}, {16'd1, 16'd2}
  };

  always #5 clk = ~clk;

  pwcap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cnt_in(cnt_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, w;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      bread(3'(a), v);
      chk("R1 reg", v, 16'd0);
    end
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2 timer mode, limit 2, ten clocks
    bwrite(3'd1, 16'd2);
    bwrite(3'd0, 16'h1);
    idle(10);
    bread(3'd6, v); chk("R2 count", v, 16'd3);
    bread(3'd7, v); chk("R2 prescaler", v, 16'd1);

    // R4 freeze
    bwrite(3'd0, 16'h0);
    bread(3'd6, v);
    idle(20);
    bread(3'd6, w); chk("R4 frozen count", w, v);

    // R5 hold-clear overrides run
    bwrite(3'd0, 16'h3);
    idle(3);
    bread(3'd6, v); chk("R5 count", v, 16'd0);
    bread(3'd7, v); chk("R5 prescaler", v, 16'd0);

    // R3 external edges, limit 1, six rising edges
    bwrite(3'd1, 16'd1);
    bwrite(3'd0, 16'h5);
    for (int k = 0; k < 6; k++) begin
      cnt_in = 1'b1; idle(2);
      cnt_in = 1'b0; idle(2);
    end
    idle(6);
    bread(3'd6, v); chk("R3 count", v, 16'd3);
    bread(3'd7, v); chk("R3 prescaler", v, 16'd0);

    // R7 pulse width: ch0 rise clears, ch1 fall captures with irq enable
    bwrite(3'd0, 16'h3);
    bwrite(3'd2, 16'h0069);
    for (int k = 0; k < 8; k++) begin
      bwrite(3'd1, VEC[k][31:16]);
      bwrite(3'd0, 16'h1);
      cap_in = 2'b11;
      idle(int'(VEC[k][15:0]));
      cap_in = 2'b00;
      idle(6);
      bread(3'd5, v);
      chk("R7 width", v, (VEC[k][15:0] - 16'd1) / (VEC[k][31:16] + 16'd1));
    end

    // R8 sticky flags, write-one-to-clear
    bread(3'd3, v); chk("R8 flag set", v, 16'd2);
    chk("R8 irq high", {15'd0, irq}, 16'd1);
    bwrite(3'd3, 16'd1);
    bread(3'd3, v); chk("R8 other bit kept", v, 16'd2);
    bwrite(3'd3, 16'd2);
    bread(3'd3, v); chk("R8 flag cleared", v, 16'd0);
    chk("R8 irq low", {15'd0, irq}, 16'd0);

    // R6 capture latency and disabled polarity
    bwrite(3'd2, 16'h0001);
    bwrite(3'd1, 16'd0);
    bwrite(3'd0, 16'h3);
    bwrite(3'd0, 16'h1);
    cap_in[0] = 1'b1;
    idle(6);
    bread(3'd4, v); chk("R6 rise capture", v, 16'd2);
    cap_in[0] = 1'b0;
    idle(6);
    bread(3'd4, v); chk("R6 fall ignored", v, 16'd2);
    bread(3'd5, w);
    cap_in[1] = 1'b1; idle(4);
    cap_in[1] = 1'b0; idle(6);
    bread(3'd5, v); chk("R6 disabled channel", v, w);
    bread(3'd3, v); chk("R8 no flag without enable", v, 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule